// File: doc/BRIEF.md
# Multi-Core Rendezvous Barrier

This block lets a group of up to eight processor cores meet at a common point in their programs and leave it together. Software names the cores that must meet by loading a participation mask, one bit per core. Each named core pulses its own arrival strobe when it reaches the meeting point, and it is then held by its waiting output. When the last named core has arrived, the barrier raises one shared release strobe. All held cores drop their waiting lines in that same cycle and continue.

After each release the barrier re-arms itself from the stored mask, so a loop of repeated meetings needs only one mask load. Cores outside the mask never wait and cannot disturb the count. An arrival that the barrier cannot use raises a sticky error flag and changes nothing else. Such an arrival comes from a core outside the mask, or from a core that has already arrived in the current round.

Top module: `rendezvous_barrier`

## Requirements
- R1: A cycle with `mask_load` high stores `mask_in` as the participation mask and arms every bit in it; bit n of every core-indexed vector belongs to core n. Arrival strobes sampled in a load cycle are ignored and raise no error.
- R2: An arrival strobe from core n while core n is armed disarms core n, and `waiting[n]` is high from the following cycle.
- R3: An arrival disarms only the arriving core's own bit; the armed state of every other core is unchanged.
- R4: When the last armed core is disarmed at a clock edge, `release_o` is high for the cycle after that edge. In that same cycle every `waiting` bit is low and all mask cores are armed again.
- R5: A core whose mask bit is zero never has `waiting` high, and its arrivals change neither the armed state nor the release.
- R6: An arrival from a core that is not armed sets `err_o`, which stays high until reset; the arrival is otherwise ignored.
- R7: Loading an all-zero mask gives a `release_o` pulse in the next cycle and leaves no core armed.
- R8: After reset, `waiting`, `release_o` and `err_o` are low and the mask is empty, so any arrival before the first load is an error.
- R9: An arrival sampled in a release cycle counts toward the next round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_load | input | 1 | Store `mask_in` and arm its cores |
| mask_in | input | NCORES | Participation mask, bit n for core n |
| arrive | input | NCORES | One-cycle arrival strobe per core |
| waiting | output | NCORES | Core has arrived and is held |
| release_o | output | 1 | One-cycle common start pulse |
| err_o | output | 1 | Sticky flag for unusable arrivals |

## Verification
The assertions expect the cores to obey the barrier: a core that has arrived holds its arrival strobe low until the release. Stray strobes are therefore the only way to repeat an arrival, and these are exactly what the error flag reports. The bench keeps to this by driving each core's strobe once per round, in a one-cycle pulse. It breaks the rule only in the dedicated error cases, and it resets after each of them. Mask loads are issued in cycles without arrivals, except in the one case that checks arrivals are dropped during a load.

// File: rtl/rb_pkg.sv
package rb_pkg;
    localparam int RB_DEF_CORES = 8;

    typedef enum logic [1:0] {
        RB_HOLD = 2'd0,
        RB_LOAD = 2'd1,
        RB_FIRE = 2'd2
    } rb_step_e;
endpackage

// File: rtl/rb_classify.sv
module rb_classify #(
    parameter int NCORES = 8
) (
    input  logic              mask_load,
    input  logic [NCORES-1:0] arrive,
    input  logic [NCORES-1:0] armed,
    output logic [NCORES-1:0] hit,
    output logic [NCORES-1:0] stray
);
    for (genvar c = 0; c < NCORES; c++) begin : g_core
        always_comb begin
            hit[c]   = arrive[c] &  armed[c] & ~mask_load;
            stray[c] = arrive[c] & ~armed[c] & ~mask_load;
        end
    end
endmodule

// File: rtl/rb_state.sv
module rb_state
    import rb_pkg::*;
#(
    parameter int NCORES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_load,
    input  logic [NCORES-1:0] mask_in,
    input  logic [NCORES-1:0] hit,
    input  logic [NCORES-1:0] stray,
    output logic [NCORES-1:0] mask_q,
    output logic [NCORES-1:0] armed_q,
    output logic              rel_q,
    output logic              err_q
);
    typedef struct packed {
        logic [NCORES-1:0] mask;
        logic [NCORES-1:0] armed;
        logic              rel;
        logic              err;
    } state_t;

    state_t   cur_q;
    state_t   nxt_d;
    rb_step_e step_d;
    logic [NCORES-1:0] left_d;

    always_comb begin
        nxt_d  = cur_q;
        left_d = cur_q.armed & ~hit;
        if (mask_load) begin
            step_d = RB_LOAD;
        end else if (cur_q.armed != '0 && left_d == '0) begin
            step_d = RB_FIRE;
        end else begin
            step_d = RB_HOLD;
        end

        unique case (step_d)
            RB_LOAD: begin
                nxt_d.mask  = mask_in;
                nxt_d.armed = mask_in;
                nxt_d.rel   = (mask_in == '0);
            end
            RB_FIRE: begin
                nxt_d.armed = cur_q.mask;
                nxt_d.rel   = 1'b1;
                nxt_d.err   = cur_q.err | (|stray);
            end
            default: begin
                nxt_d.armed = left_d;
                nxt_d.rel   = 1'b0;
                nxt_d.err   = cur_q.err | (|stray);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mask_q  = cur_q.mask;
    assign armed_q = cur_q.armed;
    assign rel_q   = cur_q.rel;
    assign err_q   = cur_q.err;

    AST_ZERO_MASK_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_load && mask_in == '0) |=> rel_q); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R6
    AST_STRAY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (|stray) |=> err_q); // R6
    AST_RELOAD_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q |-> (armed_q == mask_q)); // R4
    AST_ONLY_OWN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_load |=> (rel_q || (($past(armed_q) & ~armed_q & ~$past(hit)) == '0))); // R3
endmodule

// File: rtl/rb_waitout.sv
module rb_waitout #(
    parameter int NCORES = 8
) (
    input  logic [NCORES-1:0] mask,
    input  logic [NCORES-1:0] armed,
    output logic [NCORES-1:0] waiting
);
    for (genvar c = 0; c < NCORES; c++) begin : g_core
        assign waiting[c] = mask[c] & ~armed[c];
    end
endmodule

// File: rtl/rendezvous_barrier.sv
module rendezvous_barrier
    import rb_pkg::*;
#(
    parameter int NCORES = RB_DEF_CORES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_load,
    input  logic [NCORES-1:0] mask_in,
    input  logic [NCORES-1:0] arrive,
    output logic [NCORES-1:0] waiting,
    output logic              release_o,
    output logic              err_o
);
    logic [NCORES-1:0] hit;
    logic [NCORES-1:0] stray;
    logic [NCORES-1:0] mask_q;
    logic [NCORES-1:0] armed_q;

    rb_classify #(.NCORES(NCORES)) u_classify (
        .mask_load (mask_load),
        .arrive    (arrive),
        .armed     (armed_q),
        .hit       (hit),
        .stray     (stray)
    );

    rb_state #(.NCORES(NCORES)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_load (mask_load),
        .mask_in   (mask_in),
        .hit       (hit),
        .stray     (stray),
        .mask_q    (mask_q),
        .armed_q   (armed_q),
        .rel_q     (release_o),
        .err_q     (err_o)
    );

    rb_waitout #(.NCORES(NCORES)) u_waitout (
        .mask    (mask_q),
        .armed   (armed_q),
        .waiting (waiting)
    );

    AST_WAIT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting & ~mask_q) == '0); // R5
    AST_RELEASE_FREES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> (waiting == '0)); // R4
endmodule

// File: tb/rendezvous_barrier_tb.sv
module rendezvous_barrier_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mask_load = 1'b0;
    logic [N-1:0] mask_in = '0;
    logic [N-1:0] arrive = '0;
    logic [N-1:0] waiting;
    logic         release_o;
    logic         err_o;

    int runs = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [N-1:0] m_mask = '0;
    logic [N-1:0] m_armed = '0;
    logic         m_rel = 1'b0;
    logic         m_err = 1'b0;

    always #5 clk = ~clk;

    rendezvous_barrier #(.NCORES(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_load (mask_load),
        .mask_in   (mask_in),
        .arrive    (arrive),
        .waiting   (waiting),
        .release_o (release_o),
        .err_o     (err_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        runs++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Requirement model: one clock of the barrier
    task automatic model(input logic ld, input logic [N-1:0] m, input logic [N-1:0] a);
        logic [N-1:0] left;
        if (ld) begin
            m_mask  = m;
            m_armed = m;
            m_rel   = (m == '0);
        end else begin
            if ((a & ~m_armed) != '0) m_err = 1'b1;
            left = m_armed & ~a;
            if (m_armed != '0 && left == '0) begin
                m_rel   = 1'b1;
                m_armed = m_mask;
            end else begin
                m_rel   = 1'b0;
                m_armed = left;
            end
        end
    endtask

    task automatic step(input string tag, input logic ld, input logic [N-1:0] m,
                        input logic [N-1:0] a);
        @(negedge clk);
        mask_load = ld;
        mask_in   = m;
        arrive    = a;
        model(ld, m, a);
        @(posedge clk);
        #2;
        mask_load = 1'b0;
        arrive    = '0;
        chk({tag, " waiting"}, 32'(waiting), 32'(m_mask & ~m_armed));
        chk({tag, " release"}, 32'(release_o), 32'(m_rel));
        chk({tag, " error"}, 32'(err_o), 32'(m_err));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        m_mask = '0; m_armed = '0; m_rel = 1'b0; m_err = 1'b0;
        chk("R8 reset waiting", 32'(waiting), 32'h0);
        chk("R8 reset release", 32'(release_o), 32'h0);
        chk("R8 reset error", 32'(err_o), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R8: arrival before any load is unusable
        step("R8 arrive before load", 1'b0, '0, 4'b0001);
        do_reset();

        // R1 R2 R4 R7: every mask, cores arriving in ascending order
        for (int m = 0; m < (1 << N); m++) begin
            step("R1 R7 load", 1'b1, N'(m), '0);
            step("R4 idle after load", 1'b0, '0, '0);
            for (int c = 0; c < N; c++) begin
                if (m[c]) step("R2 R4 ascending arrival", 1'b0, '0, N'(1 << c));
            end
            step("R4 idle after round", 1'b0, '0, '0);
            // second round without reload, descending order, checks re-arm
            for (int c = N - 1; c >= 0; c--) begin
                if (m[c]) step("R4 rearmed descending", 1'b0, '0, N'(1 << c));
            end
            // whole mask arriving in one cycle
            step("R4 simultaneous", 1'b0, '0, N'(m));
            step("R4 quiet", 1'b0, '0, '0);
        end

        // R3: single arrival touches only its own bit
        step("R3 load all", 1'b1, 4'b1111, '0);
        step("R3 core1", 1'b0, '0, 4'b0010);
        step("R3 core3", 1'b0, '0, 4'b1000);

        // R9: arrival in the release cycle counts toward the next round
        step("R9 load", 1'b1, 4'b0011, '0);
        step("R9 core0", 1'b0, '0, 4'b0001);
        step("R9 core1 release", 1'b0, '0, 4'b0010);
        step("R9 arrival in release cycle", 1'b0, '0, 4'b0001);
        step("R9 second release", 1'b0, '0, 4'b0010);

        // R1: arrivals during a load cycle are dropped
        step("R1 load with arrival", 1'b1, 4'b0011, 4'b0001);
        step("R1 after load", 1'b0, '0, '0);

        // R5 R6: core outside the mask
        step("R5 load", 1'b1, 4'b0011, '0);
        step("R5 R6 outsider", 1'b0, '0, 4'b0100);
        step("R5 R6 sticky", 1'b0, '0, 4'b0001);
        step("R5 R6 release after stray", 1'b0, '0, 4'b0010);
        do_reset();

        // R6: repeated arrival by an already waiting core
        for (int c = 0; c < N; c++) begin
            step("R6 load", 1'b1, 4'b1111, '0);
            step("R6 first", 1'b0, '0, N'(1 << c));
            step("R6 repeat", 1'b0, '0, N'(1 << c));
            step("R6 held", 1'b0, '0, '0);
            do_reset();
        end

        // R7: zero mask released repeatedly
        step("R7 zero", 1'b1, '0, '0);
        step("R7 zero again", 1'b1, '0, '0);
        step("R7 quiet", 1'b0, '0, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule